// File: doc/BRIEF.md
# Instruction Fetch and Decode Sequencer

This block is the control unit for a small accumulator-style machine whose registers share one bus. A run flag, a sequence counter and a decoder produce one-hot timing signals. Combinational control terms built from those signals drive the bus select code and the load, increment and clear inputs of the registers. The program counter, address register, instruction register and indirect flag are modelled inside the block, so each transfer can be observed at the ports.

After reset the block waits. A pulse on `start_i` begins an endless fetch loop of four cycles. In the first cycle the program counter goes over the bus into the address register. In the second, the memory word at that address goes over the bus into the instruction register, and the program counter advances. In the third, the instruction is split into its indirect bit and address field. In the fourth, the counter is cleared so that the next fetch begins. There is no execute phase. The memory sits outside the block: it is read combinationally at `mem_addr_o`, which is always the address register.

Top module: `fetch_seq_unit`

## Requirements
- R1: After reset, the program counter holds `PC_INIT` and the address register, instruction register and indirect flag are zero. Every timing signal, the read strobe and the select code stay low, and the bus stays zero, until `start_i` is sampled high on a clock edge.
- R2: The first clock edge that samples `start_i` high makes `t_o[0]` active. After that, exactly one timing bit is high in each cycle, and the active bit goes 0→1→2→3→0 on successive edges.
- R3: While `t_o[0]` is active, `bus_sel_o` is 3'b010, the bus carries the program counter zero-extended, and `ar_ld_o` is high. After the edge, the address register equals the program counter.
- R4: While `t_o[1]` is active, `bus_sel_o` is 3'b111, the bus carries `mem_rdata_i`, and `ir_ld_o` and `pc_inr_o` are both high. After the edge, the instruction register holds that word and the program counter has advanced by one, modulo 2^ADDR_W.
- R5: `mem_rd_o` is high only while `t_o[1]` is active, and `mem_addr_o` always equals the address register.
- R6: While `t_o[2]` is active, `i_ld_o` and `ar_ld_o` are high and `dec_o` is one-hot at bit IR[14:12]. After the edge, the indirect flag equals IR[15] and the address register equals IR[11:0].
- R7: While `t_o[2]` or `t_o[3]` is active, `bus_sel_o` is 3'b000 and the bus is zero. `sc_clr_o` is high exactly when `t_o[3]` is active.
- R8: Once the sequence is running, `start_i` has no effect: the timing order and the register contents are the same whether or not it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins the fetch loop |
| mem_rdata_i | input | WORD_W | Memory word at `mem_addr_o` |
| mem_addr_o | output | ADDR_W | Memory address (address register) |
| mem_rd_o | output | 1 | Memory read strobe |
| bus_o | output | WORD_W | Shared bus value |
| bus_sel_o | output | 3 | Bus select code |
| t_o | output | 2^SC_W | One-hot timing signals |
| ar_ld_o | output | 1 | Address register load |
| ir_ld_o | output | 1 | Instruction register load |
| pc_inr_o | output | 1 | Program counter increment |
| i_ld_o | output | 1 | Indirect flag load |
| sc_clr_o | output | 1 | Sequence counter clear |
| pc_o | output | ADDR_W | Program counter |
| ar_o | output | ADDR_W | Address register |
| ir_o | output | WORD_W | Instruction register |
| i_o | output | 1 | Indirect flag |
| dec_o | output | 2^OP_W | One-hot opcode decode |

## Verification
The memory model returns an arithmetic hash of the address. Over 48 consecutive fetches, starting just below the top of the address space, this covers every opcode value and both values of the indirect bit. It also makes the program counter wrap to zero, which separates modular incrementing from a counter that saturates or carries into other bits. A `start_i` pulse while idle is checked to be the only thing that begins the sequence. Pulses held through mid-fetch cycles must leave the timing order and the loaded values unchanged.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    BSEL_NONE = 3'b000,
    BSEL_PC   = 3'b010,
    BSEL_MEM  = 3'b111
  } bus_sel_e;
endpackage

// File: rtl/fetch_sc_counter.sv
module fetch_sc_counter #(
  parameter int unsigned SC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            clr_i,
  output logic            run_o,
  output logic [SC_W-1:0] cnt_o
);
  logic            run_q;
  logic [SC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= start_i;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + SC_W'(1);
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/fetch_onehot_dec.sv
module fetch_onehot_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic             en_i,
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_line
    assign hot_o[g] = en_i && (code_i == IN_W'(g));
  end
endmodule

// File: rtl/fetch_ctrl_terms.sv
module fetch_ctrl_terms (
  input  logic [3:0] t_i,
  output logic [2:0] bus_sel_o,
  output logic       ar_ld_o,
  output logic       ar_from_ir_o,
  output logic       ir_ld_o,
  output logic       pc_inr_o,
  output logic       i_ld_o,
  output logic       sc_clr_o,
  output logic       mem_rd_o
);
  // each control input is an OR over the terms that request it
  logic [1:0] s1_terms;
  logic [0:0] s0_terms, s2_terms;
  logic [1:0] ar_ld_terms;
  logic [0:0] ir_ld_terms, pc_inr_terms, i_ld_terms, clr_terms, rd_terms;

  assign s0_terms     = {t_i[1]};
  assign s1_terms     = {t_i[1], t_i[0]};
  assign s2_terms     = {t_i[1]};
  assign ar_ld_terms  = {t_i[2], t_i[0]};
  assign ir_ld_terms  = {t_i[1]};
  assign pc_inr_terms = {t_i[1]};
  assign i_ld_terms   = {t_i[2]};
  assign clr_terms    = {t_i[3]};
  assign rd_terms     = {t_i[1]};

  assign bus_sel_o    = {|s2_terms, |s1_terms, |s0_terms};
  assign ar_ld_o      = |ar_ld_terms;
  assign ar_from_ir_o = t_i[2];
  assign ir_ld_o      = |ir_ld_terms;
  assign pc_inr_o     = |pc_inr_terms;
  assign i_ld_o       = |i_ld_terms;
  assign sc_clr_o     = |clr_terms;
  assign mem_rd_o     = |rd_terms;
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import fetch_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned OP_W    = 3,
  parameter logic [ADDR_W-1:0] PC_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_sel_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              ar_ld_i,
  input  logic              ar_from_ir_i,
  input  logic              ir_ld_i,
  input  logic              pc_inr_i,
  input  logic              i_ld_i,
  output logic [WORD_W-1:0] bus_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [WORD_W-1:0] ir_o,
  output logic              i_o,
  output logic [OP_W-1:0]   op_o
);
  localparam int unsigned IND_BIT = WORD_W - 1;
  localparam int unsigned OP_LSB  = ADDR_W;

  logic [ADDR_W-1:0] pc_q, ar_q, ar_d;
  logic [WORD_W-1:0] ir_q, bus;
  logic              i_q;

  always_comb begin
    unique case (bus_sel_i)
      BSEL_PC:  bus = WORD_W'(pc_q);
      BSEL_MEM: bus = mem_rdata_i;
      default:  bus = '0;
    endcase
  end

  assign ar_d = ar_from_ir_i ? ir_q[ADDR_W-1:0] : bus[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= PC_INIT;
      ar_q <= '0;
      ir_q <= '0;
      i_q  <= 1'b0;
    end else begin
      if (pc_inr_i) pc_q <= pc_q + ADDR_W'(1);
      if (ar_ld_i)  ar_q <= ar_d;
      if (ir_ld_i)  ir_q <= bus;
      if (i_ld_i)   i_q  <= ir_q[IND_BIT];
    end
  end

  assign bus_o = bus;
  assign pc_o  = pc_q;
  assign ar_o  = ar_q;
  assign ir_o  = ir_q;
  assign i_o   = i_q;
  assign op_o  = ir_q[OP_LSB +: OP_W];
endmodule

// File: rtl/fetch_seq_unit.sv
module fetch_seq_unit #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SC_W    = 4,
  parameter int unsigned OP_W    = 3,
  parameter logic [ADDR_W-1:0] PC_INIT = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic                   mem_rd_o,
  output logic [WORD_W-1:0]      bus_o,
  output logic [2:0]             bus_sel_o,
  output logic [(1<<SC_W)-1:0]   t_o,
  output logic                   ar_ld_o,
  output logic                   ir_ld_o,
  output logic                   pc_inr_o,
  output logic                   i_ld_o,
  output logic                   sc_clr_o,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [ADDR_W-1:0]      ar_o,
  output logic [WORD_W-1:0]      ir_o,
  output logic                   i_o,
  output logic [(1<<OP_W)-1:0]   dec_o
);
  localparam int unsigned NT = 1 << SC_W;

  logic            run, sc_clr, ar_from_ir;
  logic [SC_W-1:0] cnt;
  logic [NT-1:0]   t;
  logic [OP_W-1:0] op;

  fetch_sc_counter #(.SC_W(SC_W)) i_sc (
    .clk_i, .rst_ni, .start_i,
    .clr_i (sc_clr),
    .run_o (run),
    .cnt_o (cnt)
  );

  fetch_onehot_dec #(.IN_W(SC_W)) i_tdec (
    .en_i (run), .code_i (cnt), .hot_o (t)
  );

  fetch_ctrl_terms i_ctrl (
    .t_i          (t[3:0]),
    .bus_sel_o    (bus_sel_o),
    .ar_ld_o      (ar_ld_o),
    .ar_from_ir_o (ar_from_ir),
    .ir_ld_o      (ir_ld_o),
    .pc_inr_o     (pc_inr_o),
    .i_ld_o       (i_ld_o),
    .sc_clr_o     (sc_clr),
    .mem_rd_o     (mem_rd_o)
  );

  fetch_regs #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .PC_INIT(PC_INIT)
  ) i_regs (
    .clk_i, .rst_ni,
    .bus_sel_i    (bus_sel_o),
    .mem_rdata_i  (mem_rdata_i),
    .ar_ld_i      (ar_ld_o),
    .ar_from_ir_i (ar_from_ir),
    .ir_ld_i      (ir_ld_o),
    .pc_inr_i     (pc_inr_o),
    .i_ld_i       (i_ld_o),
    .bus_o        (bus_o),
    .pc_o         (pc_o),
    .ar_o         (ar_o),
    .ir_o         (ir_o),
    .i_o          (i_o),
    .op_o         (op)
  );

  fetch_onehot_dec #(.IN_W(OP_W)) i_opdec (
    .en_i (1'b1), .code_i (op), .hot_o (dec_o)
  );

  assign t_o        = t;
  assign sc_clr_o   = sc_clr;
  assign mem_addr_o = ar_o;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SC_W   = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [WORD_W-1:0]    mem_rdata_i,
  input logic [ADDR_W-1:0]    mem_addr_o,
  input logic                 mem_rd_o,
  input logic [WORD_W-1:0]    bus_o,
  input logic [(1<<SC_W)-1:0] t_o,
  input logic                 sc_clr_o,
  input logic [ADDR_W-1:0]    pc_o,
  input logic [ADDR_W-1:0]    ar_o,
  input logic [WORD_W-1:0]    ir_o,
  input logic                 i_o
);
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(t_o));
  a_r2_t0_t1: assert property (@(posedge clk_i) disable iff (!rst_ni) t_o[0] |=> t_o[1]);
  a_r2_t1_t2: assert property (@(posedge clk_i) disable iff (!rst_ni) t_o[1] |=> t_o[2]);
  a_r2_t2_t3: assert property (@(posedge clk_i) disable iff (!rst_ni) t_o[2] |=> t_o[3]);
  a_r7_t3_t0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o[3] && sc_clr_o) |=> t_o[0]);
  a_r3_ar_gets_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[0] |=> ar_o == $past(pc_o));
  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[1] |=> pc_o == ADDR_W'($past(pc_o) + ADDR_W'(1)));
  a_r4_ir_gets_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[1] |=> ir_o == $past(mem_rdata_i));
  a_r5_rd_in_t1: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_rd_o |-> t_o[1]);
  a_r5_addr_is_ar: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_addr_o == ar_o);
  a_r6_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[2] |=> (i_o == $past(ir_o[WORD_W-1])) && (ar_o == $past(ir_o[ADDR_W-1:0])));
  a_r7_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o[2] || t_o[3]) |-> bus_o == '0);
endmodule

bind fetch_seq_unit fetch_seq_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SC_W(SC_W)) i_chk (
  .clk_i, .rst_ni, .mem_rdata_i, .mem_addr_o, .mem_rd_o, .bus_o, .t_o,
  .sc_clr_o, .pc_o, .ar_o, .ir_o, .i_o
);

// File: tb/test_fetch_seq_unit.sv
`timescale 1ns/1ps
module test_fetch_seq_unit;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned SC_W   = 4;
  localparam int unsigned OP_W   = 3;
  localparam logic [ADDR_W-1:0] PC0 = 12'hFE8;
  localparam int NFETCH = 48;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WORD_W-1:0] mem_rdata, bus, ir;
  logic [ADDR_W-1:0] mem_addr, pc, ar;
  logic [2:0] bus_sel;
  logic [(1<<SC_W)-1:0] t;
  logic [(1<<OP_W)-1:0] dec;
  logic mem_rd, ar_ld, ir_ld, pc_inr, i_ld, sc_clr, i_f;
  int n_vec = 0, n_err = 0;

  always #4 clk = ~clk;

  function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return WORD_W'(int'(a) * 40503 + 4660);
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  fetch_seq_unit #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SC_W(SC_W), .OP_W(OP_W), .PC_INIT(PC0))
  i_fetch_seq_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .bus_o(bus), .bus_sel_o(bus_sel), .t_o(t),
    .ar_ld_o(ar_ld), .ir_ld_o(ir_ld), .pc_inr_o(pc_inr), .i_ld_o(i_ld), .sc_clr_o(sc_clr),
    .pc_o(pc), .ar_o(ar), .ir_o(ir), .i_o(i_f), .dec_o(dec)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] pc_exp;
    logic [WORD_W-1:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, and idle until start
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 pc", pc, PC0);
      chk("R1 ar", ar, 0);
      chk("R1 ir", ir, 0);
      chk("R1 i", i_f, 0);
      chk("R1 timing", t, 0);
      chk("R1 rd", mem_rd, 0);
      chk("R1 sel", bus_sel, 0);
      chk("R1 bus", bus, 0);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pc_exp = PC0;
    for (int f = 0; f < NFETCH; f++) begin
      // T0
      chk("R2 t0", t, 32'h1);
      chk("R3 sel", bus_sel, 3'b010);
      chk("R3 bus", bus, 32'(pc_exp));
      chk("R3 ar_ld", ar_ld, 1);
      chk("R5 rd t0", mem_rd, 0);
      chk("R7 clr t0", sc_clr, 0);
      @(negedge clk);
      // T1
      w = mem_word(pc_exp);
      chk("R3 ar=pc", ar, 32'(pc_exp));
      chk("R5 addr", mem_addr, 32'(pc_exp));
      chk("R2 t1", t, 32'h2);
      chk("R4 sel", bus_sel, 3'b111);
      chk("R4 bus", bus, 32'(w));
      chk("R4 ctl", {ir_ld, pc_inr}, 2'b11);
      chk("R5 rd t1", mem_rd, 1);
      if (f % 3 == 1) start = 1'b1;  // R8: start while running
      @(negedge clk);
      // T2
      pc_exp = pc_exp + ADDR_W'(1);
      chk("R4 ir", ir, 32'(w));
      chk("R4 pc", pc, 32'(pc_exp));
      chk("R2 t2", t, 32'h4);
      chk("R6 dec", dec, 32'(1) << w[14:12]);
      chk("R6 ctl", {i_ld, ar_ld}, 2'b11);
      chk("R5 rd t2", mem_rd, 0);
      chk("R7 sel t2", bus_sel, 0);
      chk("R7 bus t2", bus, 0);
      @(negedge clk);
      // T3
      chk("R6 i", i_f, 32'(w[15]));
      chk("R6 ar", ar, 32'(w[11:0]));
      chk("R8 pc", pc, 32'(pc_exp));
      chk("R2 t3", t, 32'h8);
      chk("R7 clr t3", sc_clr, 1);
      chk("R7 sel t3", bus_sel, 0);
      chk("R7 bus t3", bus, 0);
      chk("R5 rd t3", mem_rd, 0);
      @(negedge clk);
      start = 1'b0;
    end
    finish_run();
  end
endmodule